// File: doc/BRIEF.md
# DMA Read Request Chunk Splitter

This block sits between a descriptor engine and a memory read port. It accepts one read job at a time, given as a start byte address and a byte count. It cuts that job into a series of read requests whose sizes follow a programmable chunk rule. Each request goes out on a valid/ready request port. The memory side answers each request with one or more response beats, and the final beat of each answer is marked as last. Responses arrive in request order.

A small configuration register holds three settings: the cap on reads in flight, the largest chunk size, and a split mode. Split mode applies only to 128-byte chunks. In that mode a chunk above 64 bytes is allowed only from a 128-byte aligned address. From any other address the chunk ends at the next 64-byte boundary. The block counts the requests in flight and holds back new requests while that count is at the cap. It pulses a done flag once the final response of the job has come back, and it is then free to take the next job.

Top module: `rd_chunker`

## Requirements
- R1: After a synchronous reset, req_valid and job_done are 0 and job_ready is 1. The configuration resets to a cap of 12 in-flight reads, 64-byte chunks and split mode off.
- R2: cfg_wdata[9:8] selects the chunk size B when cfg_we is high: 0 gives 64 bytes, 1 gives 128 bytes, and 2 or 3 give 256 bytes. Outside split mode each request length is min(bytes left, B - (address mod B)), so a request never crosses a B-byte boundary and is never zero.
- R3: The first request of a job starts at the job address. Each later request starts where the previous one ended. The request lengths add up to the job length, and no request is issued once the job is fully covered.
- R4: Split mode is cfg_wdata[10]. With split mode on and B = 128, a request starting at a 128-byte aligned address has length min(bytes left, 128). Any other start address gives length min(bytes left, 64 - (address mod 64)).
- R5: The split bit has no effect when B is 64 or 256.
- R6: cfg_wdata[3:0] sets the cap on in-flight reads. No request handshake happens while the number of issued-but-unretired requests equals the cap. Once responses are withheld, the in-flight count climbs to the cap, or to the job's request count if that is lower.
- R7: A programmed cap above 12 acts as 12. A programmed cap of 0 acts as 1.
- R8: A request retires only on a beat with rsp_valid and rsp_last both high. Beats without rsp_last retire nothing.
- R9: job_done is high for exactly one cycle. That cycle is the one right after the clock edge that accepted the final last beat of the job. job_ready is low while a job is active and rises in the same cycle as job_done.
- R10: A job of length 0 issues no request. It raises job_done in the cycle after the job is accepted.
- R11: While req_valid is high and req_ready is low, req_valid, req_addr and req_len hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | Configuration value: [3:0] in-flight cap, [9:8] chunk size code, [10] split mode |
| job_valid | input | 1 | A job is offered |
| job_ready | output | 1 | The block is idle and takes a job |
| job_addr | input | ADDR_W | Job start byte address |
| job_len | input | LEN_W | Job length in bytes |
| req_valid | output | 1 | A read request is presented |
| req_ready | input | 1 | The memory port takes the request |
| req_addr | output | ADDR_W | Request start byte address |
| req_len | output | 9 | Request length in bytes, 1 to 256 |
| rsp_valid | input | 1 | A response beat is present |
| rsp_last | input | 1 | The beat is the final one of its response |
| job_done | output | 1 | One-cycle pulse when the job has fully returned |

## Verification
The sweep crosses every chunk size code and both split settings with start offsets on either side of the 64-, 128- and 256-byte boundaries, and with lengths that end just past a boundary. A wrong boundary term in the length calculation shows up as a short or overlong request, or as an address gap. Separate runs withhold responses and check that the in-flight count stops exactly at the cap. Those runs cover caps of 0, 5 and 15, where a missing clamp would let a thirteenth read escape and a zero cap would hang the job. Each response is sent as two beats, so a design that retires on every beat would overrun a cap of 1. Done-pulse timing is checked to the cycle, including for zero-length jobs, where a block that waited on a response would never finish.

// File: rtl/rc_pkg.sv
package rc_pkg;
  // Width of a request length: holds 1..256 bytes.
  localparam int RC_CHUNK_W = 9;
  // Width of the in-flight counter and cap field.
  localparam int RC_CNT_W   = 4;
  // Hard ceiling for the in-flight cap.
  localparam int RC_CAP_MAX = 12;
  // Width of the configuration write word.
  localparam int RC_CFG_W   = 11;

  localparam logic [RC_CHUNK_W-1:0] RC_B64  = RC_CHUNK_W'(64);
  localparam logic [RC_CHUNK_W-1:0] RC_B128 = RC_CHUNK_W'(128);
  localparam logic [RC_CHUNK_W-1:0] RC_B256 = RC_CHUNK_W'(256);

  typedef struct packed {
    logic [RC_CNT_W-1:0] max_out;
    logic [1:0]          size_code;
    logic                split_en;
  } rc_cfg_t;
endpackage

// File: rtl/rc_cfg_reg.sv
module rc_cfg_reg
  import rc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [RC_CFG_W-1:0] wdata,
  output rc_cfg_t             cfg
);
  logic [RC_CNT_W-1:0] cap_in;
  logic [RC_CNT_W-1:0] cap_clamped;
  logic                unused_cfg_bits;

  assign cap_in          = wdata[3:0];
  assign unused_cfg_bits = ^wdata[7:4];

  // Cap is saturated at the write so downstream compares stay plain.
  always_comb begin
    if (cap_in > RC_CNT_W'(RC_CAP_MAX))
      cap_clamped = RC_CNT_W'(RC_CAP_MAX);
    else if (cap_in == '0)
      cap_clamped = RC_CNT_W'(1);
    else
      cap_clamped = cap_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.max_out   <= RC_CNT_W'(RC_CAP_MAX);
      cfg.size_code <= 2'd0;
      cfg.split_en  <= 1'b0;
    end else if (we) begin
      cfg.max_out   <= cap_clamped;
      cfg.size_code <= wdata[9:8];
      cfg.split_en  <= wdata[10];
    end
  end
endmodule

// File: rtl/rc_chunk_calc.sv
module rc_chunk_calc
  import rc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [7:0]            addr_lo,
  input  logic [LEN_W-1:0]      rem,
  input  rc_cfg_t               cfg,
  output logic [RC_CHUNK_W-1:0] len
);
  logic [RC_CHUNK_W-1:0] lim;
  logic [RC_CHUNK_W-1:0] to64;
  logic [RC_CHUNK_W-1:0] to128;
  logic [RC_CHUNK_W-1:0] to256;

  // Distance to the next boundary of each size, from the low address byte.
  assign to64  = RC_B64  - {3'b000, addr_lo[5:0]};
  assign to128 = RC_B128 - {2'b00,  addr_lo[6:0]};
  assign to256 = RC_B256 - {1'b0,   addr_lo};

  always_comb begin
    unique case (cfg.size_code)
      2'd0: lim = to64;
      2'd1: begin
        if (cfg.split_en && (addr_lo[6:0] != 7'd0))
          lim = to64;
        else
          lim = to128;
      end
      default: lim = to256;
    endcase
  end

  assign len = (rem < LEN_W'(lim)) ? rem[RC_CHUNK_W-1:0] : lim;
endmodule

// File: rtl/rc_out_cnt.sv
module rc_out_cnt
  import rc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inc,
  input  logic                dec,
  input  logic [RC_CNT_W-1:0] limit,
  output logic [RC_CNT_W-1:0] count,
  output logic                below
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   count <= count + RC_CNT_W'(1);
        2'b01:   count <= count - RC_CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign below = (count < limit);
endmodule

// File: rtl/rd_chunker.sv
module rd_chunker
  import rc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [RC_CFG_W-1:0]   cfg_wdata,
  input  logic                  job_valid,
  output logic                  job_ready,
  input  logic [ADDR_W-1:0]     job_addr,
  input  logic [LEN_W-1:0]      job_len,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [ADDR_W-1:0]     req_addr,
  output logic [RC_CHUNK_W-1:0] req_len,
  input  logic                  rsp_valid,
  input  logic                  rsp_last,
  output logic                  job_done
);
  localparam int ADDR_PAD = ADDR_W - RC_CHUNK_W;
  localparam int LEN_PAD  = LEN_W - RC_CHUNK_W;

  rc_cfg_t               cfg_q;
  logic                  busy_q;
  logic [ADDR_W-1:0]     cur_addr_q;
  logic [LEN_W-1:0]      rem_q;
  logic                  req_valid_q;
  logic [ADDR_W-1:0]     req_addr_q;
  logic [RC_CHUNK_W-1:0] req_len_q;
  logic                  done_q;

  logic [RC_CHUNK_W-1:0] chunk;
  logic [RC_CNT_W-1:0]   out_cnt;
  logic                  below_cap;
  logic                  hs;
  logic                  retire;
  logic                  accept;
  logic                  load;
  logic                  finish;

  rc_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg_q)
  );

  rc_chunk_calc #(.LEN_W(LEN_W)) u_calc (
    .addr_lo (cur_addr_q[7:0]),
    .rem     (rem_q),
    .cfg     (cfg_q),
    .len     (chunk)
  );

  rc_out_cnt u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (hs),
    .dec   (retire),
    .limit (cfg_q.max_out),
    .count (out_cnt),
    .below (below_cap)
  );

  assign hs     = req_valid_q & req_ready;
  assign retire = rsp_valid & rsp_last & (out_cnt != '0);
  assign accept = job_valid & ~busy_q;
  assign load   = busy_q & ~req_valid_q & (rem_q != '0) & below_cap;
  // Final retire of a fully issued job.
  assign finish = busy_q & ~req_valid_q & (rem_q == '0) & retire &
                  (out_cnt == RC_CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      cur_addr_q  <= '0;
      rem_q       <= '0;
      req_valid_q <= 1'b0;
      req_addr_q  <= '0;
      req_len_q   <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cur_addr_q <= job_addr;
        rem_q      <= job_len;
        if (job_len == '0) done_q <= 1'b1;
        else               busy_q <= 1'b1;
      end
      if (hs) begin
        req_valid_q <= 1'b0;
      end else if (load) begin
        req_valid_q <= 1'b1;
        req_addr_q  <= cur_addr_q;
        req_len_q   <= chunk;
        cur_addr_q  <= cur_addr_q + {{ADDR_PAD{1'b0}}, chunk};
        rem_q       <= rem_q - {{LEN_PAD{1'b0}}, chunk};
      end
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign job_ready = ~busy_q;
  assign req_valid = req_valid_q;
  assign req_addr  = req_addr_q;
  assign req_len   = req_len_q;
  assign job_done  = done_q;
endmodule

// File: rtl/rc_checker.sv
module rc_checker
  import rc_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [7:0]            req_addr_lo,
  input logic [RC_CHUNK_W-1:0] req_len,
  input logic                  job_done,
  input logic                  job_ready,
  input logic [RC_CNT_W-1:0]   out_cnt,
  input logic [RC_CNT_W-1:0]   max_out,
  input logic [1:0]            size_code,
  input logic                  split_en
);
  a_r2_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0) && (req_len <= RC_B256));

  a_r2_no_cross_64: assert property (@(posedge clk) disable iff (rst)
    (req_valid && size_code == 2'd0) |->
      ({3'b000, req_addr_lo[5:0]} + req_len) <= RC_B64);

  a_r2_no_cross_256: assert property (@(posedge clk) disable iff (rst)
    (req_valid && size_code[1]) |->
      ({1'b0, req_addr_lo} + req_len) <= RC_B256);

  a_r4_split_stop: assert property (@(posedge clk) disable iff (rst)
    (req_valid && split_en && size_code == 2'd1 && req_addr_lo[6:0] != 7'd0) |->
      ({3'b000, req_addr_lo[5:0]} + req_len) <= RC_B64);

  a_r6_throttle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (out_cnt < max_out));

  a_r7_cap_range: assert property (@(posedge clk) disable iff (rst)
    (max_out != '0) && (max_out <= RC_CNT_W'(RC_CAP_MAX)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    job_done |=> !job_done);

  a_r9_done_ready: assert property (@(posedge clk) disable iff (rst)
    job_done |-> job_ready);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr_lo) && $stable(req_len)));
endmodule

bind rd_chunker rc_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr_lo (req_addr[7:0]),
  .req_len     (req_len),
  .job_done    (job_done),
  .job_ready   (job_ready),
  .out_cnt     (out_cnt),
  .max_out     (cfg_q.max_out),
  .size_code   (cfg_q.size_code),
  .split_en    (cfg_q.split_en)
);

// File: tb/tb_rd_chunker.sv
`timescale 1ns/1ps
module tb_rd_chunker;
  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [10:0]   cfg_wdata;
  logic          job_valid;
  logic          job_ready;
  logic [AW-1:0] job_addr;
  logic [LW-1:0] job_len;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [8:0]    req_len;
  logic          rsp_valid;
  logic          rsp_last;
  logic          job_done;

  always #2.5 clk = ~clk;

  rd_chunker #(.ADDR_W(AW), .LEN_W(LW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .job_valid(job_valid), .job_ready(job_ready), .job_addr(job_addr),
    .job_len(job_len), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid),
    .rsp_last(rsp_last), .job_done(job_done)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int m_max = 12;
  int m_code = 0;
  int m_split = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(int a, int rem, int code, int split);
    int b;
    int lim;
    b = (code == 0) ? 64 : (code == 1) ? 128 : 256;
    if (split != 0 && code == 1 && (a % 128) != 0) lim = 64 - (a % 64);
    else lim = b - (a % b);
    return (rem < lim) ? rem : lim;
  endfunction

  function automatic int eff_cap(int f);
    if (f > 12) return 12;
    if (f == 0) return 1;
    return f;
  endfunction

  task automatic cfg_write(input int capf, input int code, input int split);
    cfg_wdata = 11'(split * 1024 + code * 256 + capf);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_max = eff_cap(capf);
    m_code = code;
    m_split = split;
  endtask

  // Runs one job; stall mode withholds responses until the count settles.
  task automatic run_job(input int a, input int l, input bit stall, input int exp_sat);
    int m_addr = a;
    int m_rem = l;
    int m_out = 0;
    int beat = 0;
    int hold = 0;
    int e;
    bit exp_done = (l == 0);
    bit got_done = 1'b0;
    bit released = !stall;
    bit prev_hold = 1'b0;
    bit rdy;
    logic [AW-1:0] h_addr = '0;
    logic [8:0] h_len = '0;
    check(job_ready == 1'b1, "R9 ready when idle", int'(job_ready), 1);
    job_valid = 1'b1;
    job_addr = AW'(a);
    job_len = LW'(l);
    @(negedge clk);
    job_valid = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      if (exp_done) begin
        check(job_done == 1'b1, "R9 done pulse timing", int'(job_done), 1);
        check(job_ready == 1'b1, "R9 ready with done", int'(job_ready), 1);
        if (l == 0) check(req_valid == 1'b0, "R10 no request for empty job", int'(req_valid), 0);
        got_done = 1'b1;
        break;
      end
      if (job_done) check(1'b0, "R9 early done", 1, 0);
      if (job_ready) check(1'b0, "R9 ready while busy", 1, 0);
      if (prev_hold)
        check(req_valid && req_addr == h_addr && req_len == h_len,
              "R11 request held", int'(req_len), int'(h_len));
      rdy = stall ? 1'b1 : ((c % 4) != 2);
      req_ready = rdy;
      prev_hold = req_valid && !rdy;
      h_addr = req_addr;
      h_len = req_len;
      if (req_valid && rdy) begin
        if (m_rem <= 0) begin
          check(1'b0, "R3 request after job covered", int'(req_len), 0);
        end else begin
          e = exp_len(m_addr, m_rem, m_code, m_split);
          check(int'(req_addr) == m_addr, "R3 request address", int'(req_addr), m_addr);
          check(int'(req_len) == e, "R2 R4 R5 request length", int'(req_len), e);
          check(m_out < m_max, "R6 R8 in-flight cap", m_out + 1, m_max);
          m_addr += e;
          m_rem -= e;
          m_out++;
        end
      end
      if (!released) begin
        if (m_rem == 0 || m_out == m_max) hold++;
        else hold = 0;
        if (hold == 8) begin
          check(m_out == exp_sat, "R6 R7 in-flight count at stall", m_out, exp_sat);
          released = 1'b1;
        end
      end
      rsp_valid = 1'b0;
      rsp_last = 1'b0;
      if (released && m_out > 0 && (stall || (c % 3) != 1)) begin
        rsp_valid = 1'b1;
        if (beat == 1) begin
          rsp_last = 1'b1;
          beat = 0;
          m_out--;
          if (m_out == 0 && m_rem == 0) exp_done = 1'b1;
        end else begin
          beat = 1;
        end
      end
      @(negedge clk);
    end
    rsp_valid = 1'b0;
    rsp_last = 1'b0;
    req_ready = 1'b0;
    check(got_done, "R9 job completed", int'(got_done), 1);
    @(negedge clk);
    check(job_done == 1'b0, "R9 single-cycle done", int'(job_done), 0);
  endtask

  initial begin
    int offs[9] = '{0, 1, 63, 64, 100, 127, 128, 200, 255};
    int lens[6] = '{1, 64, 65, 130, 300, 513};
    int caps[4] = '{1, 3, 12, 7};
    int n = 0;
    rst = 1'b1;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    job_valid = 1'b0;
    job_addr = '0;
    job_len = '0;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_last = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_valid == 1'b0, "R1 reset req_valid", int'(req_valid), 0);
    check(job_done == 1'b0, "R1 reset job_done", int'(job_done), 0);
    check(job_ready == 1'b1, "R1 reset job_ready", int'(job_ready), 1);

    // R1: reset configuration is 64-byte chunks, cap 12.
    run_job(32'h10, 200, 1'b0, 0);

    // R10: zero-length job.
    run_job(32'h40, 0, 1'b0, 0);

    // R6 R7: withheld responses, cap saturation and clamping.
    cfg_write(15, 0, 0);
    run_job(32'h2000, 2000, 1'b1, 12);
    cfg_write(0, 0, 0);
    run_job(32'h2004, 300, 1'b1, 1);
    cfg_write(5, 2, 0);
    run_job(32'h3010, 2000, 1'b1, 5);
    cfg_write(12, 1, 1);
    run_job(32'h4040, 100, 1'b1, 2);

    // R2 R3 R4 R5: sweep of size code, split bit, offsets and lengths.
    for (int code = 0; code < 4; code++) begin
      for (int sp = 0; sp < 2; sp++) begin
        foreach (offs[i]) begin
          foreach (lens[j]) begin
            cfg_write(caps[n % 4], code, sp);
            run_job(32'h1000 + offs[i], lens[j], 1'b0, 0);
            n++;
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule